// File: doc/BRIEF.md
# Edit Distance Engine

This block measures how far apart two short character strings are. It returns the fewest single-character edits that turn a reference string into a comparison string. An edit is replacing one character, inserting one, or removing one. Each string is at most five 8-bit characters long. Both strings arrive packed into flat vectors with their lengths. A one-cycle start pulse begins the computation.

The engine fills the dynamic-programming table one cell per clock. It keeps only a single row of partial distances in registers, plus a diagonal register and a left-neighbour register. The control counters walk the reference characters in the outer loop and the comparison characters in the inner loop. When the final cell is written, the distance appears on the output and `done` pulses for one cycle. The distance then stays on the output until the next result replaces it. If either string is empty, the answer is the length of the other string, and it is available right away.

Top module: `edit_distance_engine`

## Requirements
- R1: After a run completes, `distance` equals the minimum number of single-character substitutions, insertions and deletions that transform the reference string into the comparison string.
- R2: Character k of a string (k = 0 is the first character) sits in bits [8k+7:8k] of its vector. Only the first `ref_len` / `cmp_len` characters take part, and bytes beyond a length have no effect on the result.
- R3: Two equal characters add no cost at their diagonal step, so identical strings of equal length give a distance of 0.
- R4: When either length is zero, `distance` equals the other length. `done` rises in the cycle right after the clock edge that accepted `start`.
- R5: With non-zero lengths n and m, `done` is high in the cycle that follows the n*m-th rising edge after the edge that accepted `start`.
- R6: `done` is high for exactly one cycle per accepted start.
- R7: Reset drives `distance` to 0 and `done` to 0. `distance` changes only in a cycle in which `done` is high.
- R8: A `start` pulse that arrives while a computation is in progress is ignored. The running result and its timing are unchanged.
- R9: A length above 5 is treated as 5, for both the result and the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation; accepted only when idle |
| ref_str | input | 40 | Reference characters, first character in the low byte |
| ref_len | input | 3 | Reference length (values above 5 are clamped) |
| cmp_str | input | 40 | Comparison characters, first character in the low byte |
| cmp_len | input | 3 | Comparison length (values above 5 are clamped) |
| distance | output | 4 | Edit distance of the last completed run |
| done | output | 1 | One-cycle pulse when `distance` is updated |

## Verification
The hardest situation to reach from the ports is a second `start` arriving in the middle of a run. The bench starts a 25-cycle computation and then, a few cycles in, pulses `start` again with strings that would give a different distance. It checks that both the final value and the cycle count belong to the first request. The other awkward points are these: an empty string on either side, a length field above five, and junk bytes sitting past a string's length. Each of these gets its own directed case. A pseudo-random sweep of short strings over a small alphabet is then compared against a full-table model written in the bench.

// File: rtl/edd_pkg.sv
package edd_pkg;

    localparam int DEF_MAX_LEN = 5;
    localparam int DEF_CHAR_W  = 8;
    localparam int DEF_DIST_W  = 4;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } edd_state_e;

    // Limits a requested length to the storage the engine has.
    function automatic int clamp_len(int len, int lim);
        return (len > lim) ? lim : len;
    endfunction

endpackage

// File: rtl/edd_cell.sv
module edd_cell #(
    parameter int DIST_W = 4,
    parameter int CHAR_W = 8
) (
    input  logic [DIST_W-1:0] up,
    input  logic [DIST_W-1:0] left,
    input  logic [DIST_W-1:0] diag,
    input  logic [CHAR_W-1:0] ch_a,
    input  logic [CHAR_W-1:0] ch_b,
    output logic [DIST_W-1:0] val
);
    logic [DIST_W-1:0] via_up, via_left, via_diag, best_ul;

    always_comb begin
        via_up   = up + DIST_W'(1);
        via_left = left + DIST_W'(1);
        via_diag = diag + DIST_W'(ch_a != ch_b);
        best_ul  = (via_up < via_left) ? via_up : via_left;
        val      = (via_diag < best_ul) ? via_diag : best_ul;
    end
endmodule

// File: rtl/edd_row.sv
module edd_row #(
    parameter int MAX_LEN = 5,
    parameter int DIST_W  = 4,
    parameter int LEN_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              wr_en,
    input  logic [LEN_W-1:0]  wr_idx,
    input  logic [DIST_W-1:0] wr_val,
    output logic [DIST_W-1:0] row_q [1:MAX_LEN]
);
    for (genvar k = 1; k <= MAX_LEN; k++) begin : g_ent
        logic [DIST_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= '0;
            else if (init)
                ent_q <= DIST_W'(k);
            else if (wr_en && wr_idx == LEN_W'(k))
                ent_q <= wr_val;
        end
        assign row_q[k] = ent_q;
    end
endmodule

// File: rtl/edd_ctrl.sv
module edd_ctrl
    import edd_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] n_in,
    input  logic [LEN_W-1:0] m_in,
    output logic             load,
    output logic             empty,
    output logic             run,
    output logic             row_end,
    output logic             last_cell,
    output logic [LEN_W-1:0] i_q,
    output logic [LEN_W-1:0] j_q
);
    edd_state_e       st_q;
    logic [LEN_W-1:0] n_q, m_q;

    assign load      = start && (st_q == ST_IDLE);
    assign empty     = (n_in == '0) || (m_in == '0);
    assign run       = (st_q == ST_RUN);
    assign row_end   = run && (j_q == m_q);
    assign last_cell = row_end && (i_q == n_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            n_q  <= '0;
            m_q  <= '0;
            i_q  <= '0;
            j_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (load) begin
                        n_q  <= n_in;
                        m_q  <= m_in;
                        i_q  <= LEN_W'(1);
                        j_q  <= LEN_W'(1);
                        st_q <= empty ? ST_IDLE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (last_cell) begin
                        st_q <= ST_IDLE;
                    end else if (row_end) begin
                        i_q <= i_q + LEN_W'(1);
                        j_q <= LEN_W'(1);
                    end else begin
                        j_q <= j_q + LEN_W'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/edit_distance_engine.sv
module edit_distance_engine
    import edd_pkg::*;
#(
    parameter int MAX_LEN  = DEF_MAX_LEN,
    parameter int CHAR_W   = DEF_CHAR_W,
    parameter int DIST_W   = DEF_DIST_W,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int STR_W   = MAX_LEN * CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [STR_W-1:0]  ref_str,
    input  logic [LEN_W-1:0]  ref_len,
    input  logic [STR_W-1:0]  cmp_str,
    input  logic [LEN_W-1:0]  cmp_len,
    output logic [DIST_W-1:0] distance,
    output logic              done
);
    logic [LEN_W-1:0]  n_in, m_in, i_w, j_w;
    logic              load_w, empty_w, run_w, row_end_w, last_w;
    logic [CHAR_W-1:0] ref_q [MAX_LEN];
    logic [CHAR_W-1:0] cmp_q [MAX_LEN];
    logic [DIST_W-1:0] row_q [1:MAX_LEN];
    logic [DIST_W-1:0] diag_q, left_q, up_w, cell_w, result_q;
    logic [CHAR_W-1:0] ch_a, ch_b;
    logic              done_q;

    assign n_in = LEN_W'(clamp_len(int'(ref_len), MAX_LEN));
    assign m_in = LEN_W'(clamp_len(int'(cmp_len), MAX_LEN));

    edd_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .n_in(n_in), .m_in(m_in),
        .load(load_w), .empty(empty_w), .run(run_w), .row_end(row_end_w),
        .last_cell(last_w), .i_q(i_w), .j_q(j_w)
    );

    // Character capture on an accepted start
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < MAX_LEN; k++) begin
                ref_q[k] <= '0;
                cmp_q[k] <= '0;
            end
        end else if (load_w) begin
            for (int k = 0; k < MAX_LEN; k++) begin
                ref_q[k] <= ref_str[k*CHAR_W +: CHAR_W];
                cmp_q[k] <= cmp_str[k*CHAR_W +: CHAR_W];
            end
        end
    end

    assign ch_a = (i_w == '0) ? '0 : ref_q[i_w - LEN_W'(1)];
    assign ch_b = (j_w == '0) ? '0 : cmp_q[j_w - LEN_W'(1)];
    assign up_w = (j_w == '0) ? '0 : row_q[j_w];

    edd_row #(.MAX_LEN(MAX_LEN), .DIST_W(DIST_W), .LEN_W(LEN_W)) u_row (
        .clk(clk), .rst(rst), .init(load_w), .wr_en(run_w),
        .wr_idx(j_w), .wr_val(cell_w), .row_q(row_q)
    );

    edd_cell #(.DIST_W(DIST_W), .CHAR_W(CHAR_W)) u_cell (
        .up(up_w), .left(left_q), .diag(diag_q),
        .ch_a(ch_a), .ch_b(ch_b), .val(cell_w)
    );

    // Neighbour registers and result
    always_ff @(posedge clk) begin
        if (rst) begin
            diag_q   <= '0;
            left_q   <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_w) begin
                diag_q <= '0;
                left_q <= DIST_W'(1);
                if (empty_w) begin
                    result_q <= DIST_W'(n_in) + DIST_W'(m_in);
                    done_q   <= 1'b1;
                end
            end else if (run_w) begin
                if (row_end_w) begin
                    diag_q <= DIST_W'(i_w);
                    left_q <= DIST_W'(i_w) + DIST_W'(1);
                end else begin
                    diag_q <= up_w;
                    left_q <= cell_w;
                end
                if (last_w) begin
                    result_q <= cell_w;
                    done_q   <= 1'b1;
                end
            end
        end
    end

    assign distance = result_q;
    assign done     = done_q;
endmodule

// File: rtl/edd_chk.sv
module edd_chk #(
    parameter int MAX_LEN = 5,
    parameter int DIST_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic [DIST_W-1:0] distance,
    input logic              run,
    input logic              last_cell
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    dist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(distance) |-> done);

    // R1
    dist_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (distance <= DIST_W'(MAX_LEN)));

    // R8
    run_continue_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !last_cell) |=> run);

    // R5
    finish_done_chk: assert property (@(posedge clk) disable iff (rst)
        last_cell |=> done);
endmodule

bind edit_distance_engine edd_chk #(.MAX_LEN(MAX_LEN), .DIST_W(DIST_W)) u_chk (
    .clk(clk), .rst(rst), .done(done), .distance(distance),
    .run(run_w), .last_cell(last_w)
);

// File: tb/sim_edit_distance_engine.sv
module sim_edit_distance_engine;
    localparam int ML = 5;
    localparam int SW = ML * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [SW-1:0] ref_str = '0, cmp_str = '0;
    logic [2:0]    ref_len = '0, cmp_len = '0;
    logic [3:0]    distance;
    logic          done;
    int            n_checks = 0;
    int            n_errors = 0;
    logic [31:0]   seed = 32'h1234_5677;

    always #2 clk = ~clk;

    edit_distance_engine u0 (
        .clk(clk), .rst(rst), .start(start), .ref_str(ref_str), .ref_len(ref_len),
        .cmp_str(cmp_str), .cmp_len(cmp_len), .distance(distance), .done(done)
    );

    function automatic logic [SW-1:0] pk(string s);
        logic [SW-1:0] v = '0;
        for (int k = 0; k < s.len() && k < ML; k++) v[k*8 +: 8] = s[k];
        return v;
    endfunction

    // Full-table reference model
    function automatic int model(logic [SW-1:0] a, int n, logic [SW-1:0] b, int m);
        int d [ML+1][ML+1];
        int c, x;
        if (n > ML) n = ML;
        if (m > ML) m = ML;
        for (int i = 0; i <= n; i++) d[i][0] = i;
        for (int j = 0; j <= m; j++) d[0][j] = j;
        for (int i = 1; i <= n; i++)
            for (int j = 1; j <= m; j++) begin
                c = (a[(i-1)*8 +: 8] == b[(j-1)*8 +: 8]) ? 0 : 1;
                x = d[i-1][j] + 1;
                if (d[i][j-1] + 1 < x) x = d[i][j-1] + 1;
                if (d[i-1][j-1] + c < x) x = d[i-1][j-1] + c;
                d[i][j] = x;
            end
        return d[n][m];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issues one start, waits for done, checks value, latency, pulse width and hold.
    task automatic run_case(string req, logic [SW-1:0] a, int n, logic [SW-1:0] b, int m, int exp);
        int cyc = 0;
        int nn = (n > ML) ? ML : n;
        int mm = (m > ML) ? ML : m;
        logic [3:0] held;
        @(negedge clk);
        ref_str = a; ref_len = 3'(n); cmp_str = b; cmp_len = 3'(m); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, {req, " done seen (watchdog)"}, int'(done), 1);
        chk(distance == 4'(exp), {req, " distance"}, int'(distance), exp);
        chk(cyc == nn * mm, {req, " R5 latency"}, cyc, nn * mm);
        held = distance;
        @(negedge clk);
        chk(!done, {req, " R6 single pulse"}, int'(done), 0);
        chk(distance == held, {req, " R7 hold"}, int'(distance), int'(held));
    endtask

    task automatic test_reset();
        chk(distance == 4'd0, "R7 reset distance", int'(distance), 0);
        chk(done == 1'b0, "R7 reset done", int'(done), 0);
    endtask

    task automatic test_known();
        run_case("R1 HOUSE/MOUSE", pk("HOUSE"), 5, pk("MOUSE"), 5, 1);
        run_case("R1 ABCDE/EDCBA", pk("ABCDE"), 5, pk("EDCBA"), 5, 4);
        run_case("R1 FLAW/LAWN",   pk("FLAW"),  4, pk("LAWN"),  4, 2);
        run_case("R1 ABC/XABCY",   pk("ABC"),   3, pk("XABCY"), 5, 2);
        run_case("R1 ABCDE/XYZ",   pk("ABCDE"), 5, pk("XYZ"),   3, 5);
    endtask

    task automatic test_identical();
        run_case("R3 identical", pk("QWERT"), 5, pk("QWERT"), 5, 0);
        run_case("R3 single match", pk("K"), 1, pk("K"), 1, 0);
    endtask

    task automatic test_empty();
        run_case("R4 empty ref", pk(""), 0, pk("ABC"), 3, 3);
        run_case("R4 empty cmp", pk("AB"), 2, pk("ZZZZZ"), 0, 2);
        run_case("R4 both empty", pk("XYZ"), 0, pk("XYZ"), 0, 0);
    endtask

    task automatic test_trailing();
        run_case("R2 bytes past length", pk("ABQRS"), 2, pk("ABXYZ"), 2, 0);
    endtask

    task automatic test_clamp();
        run_case("R9 length clamp", pk("ABCDE"), 7, pk("ABCDE"), 6, 0);
    endtask

    task automatic test_busy();
        int cyc = 0;
        @(negedge clk);
        ref_str = pk("ABCDE"); ref_len = 3'd5; cmp_str = pk("VWXYZ"); cmp_len = 3'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) begin @(negedge clk); cyc++; end
        ref_str = pk("AAAAA"); ref_len = 3'd1; cmp_str = pk("AAAAA"); cmp_len = 3'd1; start = 1'b1;
        @(negedge clk); cyc++;
        start = 1'b0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk(distance == 4'd5, "R8 start ignored while busy: value", int'(distance), 5);
        chk(cyc == 25, "R8 start ignored while busy: latency", cyc, 25);
        @(negedge clk);
        chk(!done, "R8 no second completion", int'(done), 0);
    endtask

    task automatic test_sweep();
        logic [SW-1:0] a, b;
        int n, m;
        for (int t = 0; t < 20; t++) begin
            a = '0; b = '0;
            seed = seed * 32'd1103515245 + 32'd12345;
            n = int'(seed[18:16]) % 6;
            m = int'(seed[22:20]) % 6;
            for (int k = 0; k < ML; k++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                a[k*8 +: 8] = 8'h41 + 8'(seed[17:16]);
                b[k*8 +: 8] = 8'h41 + 8'(seed[21:20]);
            end
            run_case("R1 sweep", a, n, b, m, model(a, n, b, m));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        test_known();
        test_identical();
        test_empty();
        test_trailing();
        test_clamp();
        test_busy();
        test_sweep();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule